// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an eight-pin general-purpose I/O port attached to a small microcontroller register bus. Software reaches three registers: an output latch that also serves as the data register, a direction register and a pull-up enable register. Bit n of every register belongs to pin n. Each pin is presented to the pad as an output value, an output enable and a pull-up enable. A separate pad input vector returns the pin level.

A peripheral can claim the output driver of any pin by raising its per-pin output enable. Its output value then replaces the latch bit on that pin. The pin levels pass through a two-flop synchroniser. They are then sent continuously to the external-interrupt logic and to the peripheral inputs, whatever the direction setting. A low-power stop request combined with a pin-level control bit puts every pin into a safe state: no driver and no pull-up.

Reads of the data register return the synchronised pin levels. A read flagged as part of a read-modify-write cycle returns the latch instead, so pins set as inputs are not written back with the levels seen on the pads.

Top module: `pio_port`

## Requirements
- R1: After reset the latch, direction and pull-up registers all read 0, and pad_oe and pad_pu are all 0.
- R2: With bus_wr high at a rising edge, bus_wdata is stored into the register chosen by bus_sel (0 = data latch, 1 = direction, 2 = pull-up). The new value is visible from that edge on. Bit n acts on pin n.
- R3: A read with bus_sel = 0 and bus_rmw = 0 returns the synchronised pin levels. These are pad_in delayed by two rising edges.
- R4: A read with bus_sel = 0 and bus_rmw = 1 returns the data latch and not the pin levels.
- R5: On a pin with no peripheral output and no stop forcing, a direction bit of 1 sets pad_oe and a direction bit of 0 clears it. pad_out always carries the latch bit on such a pin.
- R6: When periph_oe[n] is 1 and stop forcing is off, pad_oe[n] is 1 and pad_out[n] equals periph_out[n].
- R7: pad_pu[n] is 1 only when the direction bit is 0, the pull-up bit is 1, periph_oe[n] is 0 and stop forcing is off.
- R8: Stop forcing is active when stop_mode and stop_pin_ctl are both 1. It clears all of pad_oe and pad_pu and leaves the registers unchanged. stop_mode alone changes nothing.
- R9: ext_irq_lvl and periph_in both equal the synchronised pin levels, whatever the direction and pull-up settings.
- R10: bus_rdata is 0 whenever bus_rd is 0. Selector 3 reads as 0, and writes to it change no register.
- R11: The direction and pull-up registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register selector: 0 latch, 1 direction, 2 pull-up, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks the read as part of a read-modify-write cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| periph_oe | input | 8 | Per-pin peripheral output enable |
| periph_out | input | 8 | Per-pin peripheral output value |
| stop_mode | input | 1 | Stop mode active |
| stop_pin_ctl | input | 1 | Pin-level control for stop mode; 1 makes the pins safe |
| pad_in | input | 8 | Level seen on each pad |
| pad_out | output | 8 | Value to drive on each pad |
| pad_oe | output | 8 | Driver enable per pad |
| pad_pu | output | 8 | Pull-up enable per pad |
| ext_irq_lvl | output | 8 | Synchronised pin levels to the external-interrupt logic |
| periph_in | output | 8 | Synchronised pin levels to the peripherals |

## Verification
The assertions assume that every input is known (no X) and changes only between clock edges. They also assume that pad_in is the only asynchronous input, so the two-edge latency check on the synchronised levels is exact. The bench changes every input at the falling clock edge and samples outputs just after it. Each stimulus value is held for at least two rising edges before a pin-level result is taken.

// File: rtl/pio_port.sv
module pio_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_rmw,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] periph_oe,
  input  logic [WIDTH-1:0] periph_out,
  input  logic             stop_mode,
  input  logic             stop_pin_ctl,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu,
  output logic [WIDTH-1:0] ext_irq_lvl,
  output logic [WIDTH-1:0] periph_in
);

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_DIR  = 2'd1;
  localparam logic [1:0] SEL_PULL = 2'd2;

  logic [WIDTH-1:0] latch_q, dir_q, pull_q;
  logic [WIDTH-1:0] sync_q [SYNC_STAGES];
  logic [WIDTH-1:0] pin_lvl, rd_val;
  logic             safe_force;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
    end else if (bus_wr) begin
      case (bus_sel)
        SEL_DATA: latch_q <= bus_wdata;
        SEL_DIR:  dir_q   <= bus_wdata;
        SEL_PULL: pull_q  <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pad_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign pin_lvl     = sync_q[SYNC_STAGES-1];
  assign ext_irq_lvl = pin_lvl;
  assign periph_in   = pin_lvl;

  assign safe_force = stop_mode & stop_pin_ctl;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_pin
      assign pad_out[g] = periph_oe[g] ? periph_out[g] : latch_q[g];
      assign pad_oe[g]  = ~safe_force & (periph_oe[g] | dir_q[g]);
      assign pad_pu[g]  = ~safe_force & pull_q[g] & ~dir_q[g] & ~periph_oe[g];
    end
  endgenerate

  always_comb begin
    case (bus_sel)
      SEL_DATA: rd_val = bus_rmw ? latch_q : pin_lvl;
      SEL_DIR:  rd_val = dir_q;
      SEL_PULL: rd_val = pull_q;
      default:  rd_val = '0;
    endcase
  end

  assign bus_rdata = bus_rd ? rd_val : '0;

endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_sel,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_rmw,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] periph_oe,
  input logic [WIDTH-1:0] periph_out,
  input logic             stop_mode,
  input logic             stop_pin_ctl,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_pu,
  input logic [WIDTH-1:0] ext_irq_lvl,
  input logic [WIDTH-1:0] periph_in
);

  logic [1:0] warm;
  logic       forced;

  assign forced = stop_mode & stop_pin_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd1) |=> (forced || periph_oe != '0 || pad_oe == $past(bus_wdata)));

  assert_pin_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_rmw && bus_sel == 2'd0) |-> bus_rdata == ext_irq_lvl);

  assert_rmw_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_rmw && bus_sel == 2'd0 && periph_oe == '0) |-> bus_rdata == pad_out);

  assert_periph_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !forced |-> ((pad_out & periph_oe) == (periph_out & periph_oe) && (pad_oe & periph_oe) == periph_oe));

  assert_pull_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & (pad_oe | periph_oe)) == '0);

  assert_stop_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    forced |-> (pad_oe == '0 && pad_pu == '0));

  assert_levels_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq_lvl == periph_in);

  generate
    if (SYNC_STAGES == 2) begin : g_lat
      assert_sync_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> ext_irq_lvl == $past(pad_in, 2));
    end
  endgenerate

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);

endmodule

bind pio_port pio_port_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) chk_i (.*);

// File: tb/pio_port_test.sv
`timescale 1ns/1ps
module pio_port_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   bus_sel = '0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0, bus_rmw = 1'b0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic [W-1:0] periph_oe = '0, periph_out = '0;
  logic         stop_mode = 1'b0, stop_pin_ctl = 1'b0;
  logic [W-1:0] pad_in = '0, pad_out, pad_oe, pad_pu, ext_irq_lvl, periph_in;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  string        q_req [$];
  int           q_sig [$];
  logic [W-1:0] q_exp [$];
  event         sample_ev;

  always #2 clk = ~clk;

  pio_port #(.WIDTH(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rmw(bus_rmw), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_oe(periph_oe), .periph_out(periph_out), .stop_mode(stop_mode),
    .stop_pin_ctl(stop_pin_ctl), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .ext_irq_lvl(ext_irq_lvl), .periph_in(periph_in));

  function automatic logic [W-1:0] pick(int sig);
    case (sig)
      0: return bus_rdata;
      1: return pad_out;
      2: return pad_oe;
      3: return pad_pu;
      4: return ext_irq_lvl;
      default: return periph_in;
    endcase
  endfunction

  initial begin : monitor
    forever begin
      @(sample_ev);
      while (q_req.size() > 0) begin
        automatic string        r = q_req.pop_front();
        automatic int           s = q_sig.pop_front();
        automatic logic [W-1:0] e = q_exp.pop_front();
        automatic logic [W-1:0] a = pick(s);
        n_checks++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: signal %0d actual %h expected %h", r, s, a, e);
        end
      end
    end
  end

  task automatic expect_val(string r, int sig, logic [W-1:0] e);
    q_req.push_back(r); q_sig.push_back(sig); q_exp.push_back(e);
  endtask

  task automatic flush();
    #0.5;
    -> sample_ev;
    wait (q_req.size() == 0);
  endtask

  task automatic wr(logic [1:0] sel, logic [W-1:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string r, logic [1:0] sel, logic rmw, logic [W-1:0] e);
    @(negedge clk);
    bus_sel = sel; bus_rmw = rmw; bus_rd = 1'b1;
    expect_val(r, 0, e);
    flush();
    bus_rd = 1'b0; bus_rmw = 1'b0;
  endtask

  task automatic outs(string r, logic [W-1:0] o, logic [W-1:0] oe, logic [W-1:0] pu);
    @(negedge clk);
    expect_val(r, 1, o); expect_val(r, 2, oe); expect_val(r, 3, pu);
    flush();
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    outs("R1", 8'h00, 8'h00, 8'h00);
    rd_chk("R1", 2'd1, 1'b0, 8'h00);
    rd_chk("R1", 2'd2, 1'b0, 8'h00);
    rd_chk("R1", 2'd0, 1'b1, 8'h00);

    // R2 R5 latch and direction
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'hF0);
    outs("R2_R5", 8'hA5, 8'hF0, 8'h00);
    rd_chk("R4", 2'd0, 1'b1, 8'hA5);

    // R3 R9 synchronised pin levels with two-edge latency
    @(negedge clk); pad_in = 8'h3C;
    @(negedge clk);
    expect_val("R9 latency", 4, 8'h00);
    flush();
    @(negedge clk);
    expect_val("R9", 4, 8'h3C); expect_val("R9", 5, 8'h3C);
    flush();
    rd_chk("R3", 2'd0, 1'b0, 8'h3C);
    rd_chk("R4 latch not pins", 2'd0, 1'b1, 8'hA5);

    // R7 pull-up only on inputs; R11 readback
    wr(2'd2, 8'hFF);
    outs("R7", 8'hA5, 8'hF0, 8'h0F);
    rd_chk("R11", 2'd1, 1'b0, 8'hF0);
    rd_chk("R11", 2'd2, 1'b0, 8'hFF);

    // R6 peripheral takeover
    @(negedge clk); periph_oe = 8'h03; periph_out = 8'h02;
    outs("R6", 8'hA6, 8'hF3, 8'h0C);

    // R8 stop forcing
    @(negedge clk); stop_mode = 1'b1;
    outs("R8 no ctl", 8'hA6, 8'hF3, 8'h0C);
    @(negedge clk); stop_pin_ctl = 1'b1;
    outs("R8 forced", 8'hA6, 8'h00, 8'h00);
    rd_chk("R8 latch kept", 2'd0, 1'b1, 8'hA5);
    @(negedge clk); stop_mode = 1'b0; stop_pin_ctl = 1'b0;
    outs("R8 released", 8'hA6, 8'hF3, 8'h0C);
    @(negedge clk); periph_oe = '0; periph_out = '0;

    // R10 idle bus and unused selector
    @(negedge clk); bus_sel = 2'd1; bus_rd = 1'b0;
    expect_val("R10 idle", 0, 8'h00);
    flush();
    rd_chk("R10 sel3", 2'd3, 1'b0, 8'h00);
    wr(2'd3, 8'h55);
    rd_chk("R10 sel3 write", 2'd0, 1'b1, 8'hA5);
    rd_chk("R10 sel3 write", 2'd1, 1'b0, 8'hF0);
    rd_chk("R10 sel3 write", 2'd2, 1'b0, 8'hFF);

    // R9 levels forwarded with all pins as outputs; R5 direction low clears drivers
    wr(2'd1, 8'hFF);
    @(negedge clk); pad_in = 8'h81;
    repeat (2) @(negedge clk);
    expect_val("R9 outputs", 4, 8'h81); expect_val("R9 outputs", 5, 8'h81);
    flush();
    outs("R5 all out", 8'hA5, 8'hFF, 8'h00);
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'h00);
    outs("R5 R7 low", 8'hA5, 8'h0F, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule